// File: doc/BRIEF.md
# Opcode Group Decoder

This block classifies the first 16-bit word of an instruction from a legacy two-operand CISC instruction set. It assigns the word an operation class and reports the operand size, the raw register, mode and condition fields, a quick constant or shift count, and the number of extension words that the opcode itself requires. It also flags illegal encodings and raises separate indications for the two reserved unimplemented-line groups. Extension words needed by effective-address modes are not counted. The block does not execute the operation.

A `cpu_level` input selects the processor generation: 0 for the base model, 1 for the second generation, 2 or more for the third generation and later. Several encodings decode differently at different levels. One word is decoded on every cycle in which `in_valid` is high. The result is registered and appears one clock later with `out_valid` set.

Top module: `cisc_opdec`

## Requirements
- R1: Each word accepted while `in_valid` is high produces its result on the next rising edge with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next edge. Reset clears `out_valid` and sets `out_op` to 0. `out_reg_hi`, `out_cond`, `out_mode_lo` and `out_reg_lo` always echo word bits 11:9, 11:8, 5:3 and 2:0.
- R2: Words in group 0xA (bits 15:12) give `out_op`=30 with `out_line_a`=1. Words in group 0xF give `out_op`=31 with `out_line_f`=1. Neither sets `out_illegal`.
- R3: A group-0 word with (w & 0x13F)==0x03C performs an immediate logic operation. When bits 7:6=00 it acts on the condition byte (size 0): OR 2, AND 3, EOR 4. When bits 7:6=01 it acts on the status word (size 1): OR 5, AND 6, EOR 7. Bits 11:8 select OR=0000, AND=0010, EOR=1010. Each of these has one extension word. Any other combination of bits 11:8 or bits 7:6 gives `out_op`=32 with `out_illegal`=1.
- R4: A group-7 word with bit 8 clear gives `out_op`=8 at size 2. A group-7 word with bit 8 set gives `out_op`=32 with `out_illegal`=1.
- R5: A group-5 word with size field (bits 7:6) other than 11 gives add-quick (`out_op`=9) when bit 8 is clear, or subtract-quick (10) when bit 8 is set. `out_size` equals bits 7:6. `out_quick` is bits 11:9, with 0 meaning 8.
- R6: A group-5 word with size field 11 gives decrement-and-branch (`out_op`=12, one extension word) when bits 5:3=001, and set-on-condition (11, no extension word) otherwise. In both cases `out_size` is 3.
- R7: A group-E word with size field other than 11 shifts a register. `out_op` is 16+bits 4:3 (arithmetic, logical, rotate-through-extend, rotate). `out_shift_left` equals bit 8. When bit 5 is clear, `out_quick` is bits 11:9 with 0 meaning 8. When bit 5 is set, `out_count_reg`=1 and `out_quick`=0.
- R8: A group-E word with size field 11 and bit 11 clear shifts memory by one bit. `out_op` is 16+bits 10:9, `out_size`=1 and `out_quick`=1. A group-E word with size field 11 and bit 11 set gives `out_op`=0.
- R9: A group-4 word with bit 8 set and bit 6 clear is a bounds check (`out_op`=20). It is word size (1) when bit 7 is set. When bit 7 is clear it is long size (2) only at `cpu_level`>=2, and word size below that.
- R10: A group-4 word with bits 11:6=001011 reads the condition codes (`out_op`=21, size 1) at `cpu_level`>=1. At level 0 it gives `out_op`=32 with `out_illegal`=1.
- R11: Word 0x4AFC gives `out_op`=1 with `out_illegal`=1. Words 0x4E70..0x4E77 give `out_op` 22..29 in order. Codes 24 (0x4E72) and 26 (0x4E74) have one extension word. 0x4E74 needs `cpu_level`>=1; at level 0 it gives `out_op`=32 with `out_illegal`=1.
- R12: A group-6 word with condition field (bits 11:8) 0 gives `out_op`=13, with condition 1 it gives 14, and otherwise 15. When the low byte is 0x00 the displacement is size 1 with one extension word. When the low byte is 0xFF and `cpu_level`>=2 it is size 2 with two extension words. Otherwise it is size 0 with none.
- R13: Every word that no other rule classifies gives `out_op`=0, `out_size`=3, no extension words and `out_illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is presented this cycle |
| in_word | input | 16 | First opcode word |
| cpu_level | input | 2 | Processor generation: 0, 1, 2 or more |
| out_valid | output | 1 | Decoded result present |
| out_op | output | 6 | Operation class code |
| out_size | output | 2 | 0 byte, 1 word, 2 long, 3 none |
| out_cond | output | 4 | Bits 11:8 of the word |
| out_reg_hi | output | 3 | Bits 11:9 of the word |
| out_mode_lo | output | 3 | Bits 5:3 of the word |
| out_reg_lo | output | 3 | Bits 2:0 of the word |
| out_quick | output | 4 | Quick constant or immediate shift count (1..8), else 0 |
| out_shift_left | output | 1 | Shift or rotate is to the left |
| out_count_reg | output | 1 | Shift count comes from a data register |
| out_ext_words | output | 2 | Extension words the opcode itself requires |
| out_illegal | output | 1 | Illegal-instruction indication |
| out_line_a | output | 1 | Unimplemented line-A group |
| out_line_f | output | 1 | Unimplemented line-F group |

## Verification
The bench builds the decoder with its default level thresholds: long bounds check and long branches from level 2, condition-code read and return-and-deallocate from level 1. It then applies the same word at several values of `cpu_level`, so each side of every threshold is exercised. The vectors include the count fields where zero means eight, the 0x00 and 0xFF branch displacement bytes, and the illegal combinations inside the immediate-logic and move-quick groups.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    typedef enum logic [5:0] {
        OP_OTHER     = 6'd0,
        OP_ILL_WORD  = 6'd1,
        OP_OR_CC     = 6'd2,
        OP_AND_CC    = 6'd3,
        OP_EOR_CC    = 6'd4,
        OP_OR_SR     = 6'd5,
        OP_AND_SR    = 6'd6,
        OP_EOR_SR    = 6'd7,
        OP_QMOVE     = 6'd8,
        OP_QADD      = 6'd9,
        OP_QSUB      = 6'd10,
        OP_SETCOND   = 6'd11,
        OP_DECBR     = 6'd12,
        OP_BR_ALWAYS = 6'd13,
        OP_BR_SUB    = 6'd14,
        OP_BR_COND   = 6'd15,
        OP_SH_ARITH  = 6'd16,
        OP_SH_LOGIC  = 6'd17,
        OP_SH_ROTX   = 6'd18,
        OP_SH_ROT    = 6'd19,
        OP_BOUNDS    = 6'd20,
        OP_RD_CC     = 6'd21,
        OP_CTL_BASE  = 6'd22,
        OP_LINE_A    = 6'd30,
        OP_LINE_F    = 6'd31,
        OP_INVALID   = 6'd32
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    typedef struct packed {
        op_e        op;
        size_e      size;
        logic [1:0] ext;
        logic       illegal;
        logic [3:0] quick;
        logic       shift_left;
        logic       count_reg;
    } dec_t;

    localparam dec_t DEC_OTHER = '{op: OP_OTHER, size: SZ_NONE, ext: 2'd0,
                                   illegal: 1'b0, quick: 4'd0,
                                   shift_left: 1'b0, count_reg: 1'b0};

    localparam dec_t DEC_INVALID = '{op: OP_INVALID, size: SZ_NONE, ext: 2'd0,
                                     illegal: 1'b1, quick: 4'd0,
                                     shift_left: 1'b0, count_reg: 1'b0};

    // three-bit count field where zero stands for eight
    function automatic logic [3:0] quick_of(input logic [2:0] f);
        return (f == 3'd0) ? 4'd8 : {1'b0, f};
    endfunction

endpackage

// File: rtl/opdec_imm_logic.sv
module opdec_imm_logic
    import opdec_pkg::*;
(
    input  logic [11:0] w,
    output dec_t        dec
);
    always_comb begin
        dec = DEC_OTHER;
        if ((w & 12'h13F) == 12'h03C) begin
            dec = DEC_INVALID;
            if (w[7:6] == 2'b00) begin
                case (w[11:8])
                    4'b0000: dec.op = OP_OR_CC;
                    4'b0010: dec.op = OP_AND_CC;
                    4'b1010: dec.op = OP_EOR_CC;
                    default: dec.op = OP_INVALID;
                endcase
                if (dec.op != OP_INVALID) begin
                    dec.illegal = 1'b0;
                    dec.size    = SZ_BYTE;
                    dec.ext     = 2'd1;
                end
            end else if (w[7:6] == 2'b01) begin
                case (w[11:8])
                    4'b0000: dec.op = OP_OR_SR;
                    4'b0010: dec.op = OP_AND_SR;
                    4'b1010: dec.op = OP_EOR_SR;
                    default: dec.op = OP_INVALID;
                endcase
                if (dec.op != OP_INVALID) begin
                    dec.illegal = 1'b0;
                    dec.size    = SZ_WORD;
                    dec.ext     = 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/opdec_misc.sv
module opdec_misc
    import opdec_pkg::*;
#(
    parameter int LVL_W          = 2,
    parameter int CHK_LONG_LEVEL = 2,
    parameter int CC_READ_LEVEL  = 1,
    parameter int RET_DEAL_LEVEL = 1
) (
    input  logic [11:0]      w,
    input  logic [LVL_W-1:0] lvl,
    output dec_t             dec
);
    localparam logic [8:0] CTL_PREFIX = 9'b1110_0111_0;
    localparam logic [2:0] CTL_STOP   = 3'd2;
    localparam logic [2:0] CTL_RETDEA = 3'd4;

    logic [2:0] ctl;
    assign ctl = w[2:0];

    always_comb begin
        dec = DEC_OTHER;
        if (w == 12'hAFC) begin
            dec.op      = OP_ILL_WORD;
            dec.illegal = 1'b1;
        end else if (w[11:3] == CTL_PREFIX) begin
            dec.op = op_e'(6'd22 + {3'b000, ctl});
            if (ctl == CTL_STOP || ctl == CTL_RETDEA)
                dec.ext = 2'd1;
            if (ctl == CTL_RETDEA && int'(lvl) < RET_DEAL_LEVEL)
                dec = DEC_INVALID;
        end else if (w[8] && !w[6]) begin
            dec.op = OP_BOUNDS;
            if (w[7] || int'(lvl) < CHK_LONG_LEVEL)
                dec.size = SZ_WORD;
            else
                dec.size = SZ_LONG;
        end else if (w[11:6] == 6'b001011) begin
            if (int'(lvl) >= CC_READ_LEVEL) begin
                dec.op   = OP_RD_CC;
                dec.size = SZ_WORD;
            end else begin
                dec = DEC_INVALID;
            end
        end
    end
endmodule

// File: rtl/opdec_qbm.sv
module opdec_qbm
    import opdec_pkg::*;
#(
    parameter int LVL_W          = 2,
    parameter int LONG_BR_LEVEL  = 2
) (
    input  logic [13:0]      w,
    input  logic [LVL_W-1:0] lvl,
    output dec_t             dec
);
    always_comb begin
        dec = DEC_OTHER;
        case (w[13:12])
            2'b01: begin
                if (w[7:6] != 2'b11) begin
                    dec.op    = w[8] ? OP_QSUB : OP_QADD;
                    dec.size  = size_e'(w[7:6]);
                    dec.quick = quick_of(w[11:9]);
                end else if (w[5:3] == 3'b001) begin
                    dec.op  = OP_DECBR;
                    dec.ext = 2'd1;
                end else begin
                    dec.op = OP_SETCOND;
                end
            end
            2'b10: begin
                case (w[11:8])
                    4'd0:    dec.op = OP_BR_ALWAYS;
                    4'd1:    dec.op = OP_BR_SUB;
                    default: dec.op = OP_BR_COND;
                endcase
                if (w[7:0] == 8'h00) begin
                    dec.size = SZ_WORD;
                    dec.ext  = 2'd1;
                end else if (w[7:0] == 8'hFF && int'(lvl) >= LONG_BR_LEVEL) begin
                    dec.size = SZ_LONG;
                    dec.ext  = 2'd2;
                end else begin
                    dec.size = SZ_BYTE;
                end
            end
            2'b11: begin
                if (w[8]) begin
                    dec = DEC_INVALID;
                end else begin
                    dec.op   = OP_QMOVE;
                    dec.size = SZ_LONG;
                end
            end
            default: dec = DEC_OTHER;
        endcase
    end
endmodule

// File: rtl/opdec_shift.sv
module opdec_shift
    import opdec_pkg::*;
(
    input  logic [11:0] w,
    output dec_t        dec
);
    always_comb begin
        dec = DEC_OTHER;
        if (w[7:6] != 2'b11) begin
            dec.op         = op_e'(6'd16 + {4'b0000, w[4:3]});
            dec.size       = size_e'(w[7:6]);
            dec.shift_left = w[8];
            if (w[5])
                dec.count_reg = 1'b1;
            else
                dec.quick = quick_of(w[11:9]);
        end else if (!w[11]) begin
            dec.op         = op_e'(6'd16 + {4'b0000, w[10:9]});
            dec.size       = SZ_WORD;
            dec.shift_left = w[8];
            dec.quick      = 4'd1;
        end
    end
endmodule

// File: rtl/cisc_opdec.sv
module cisc_opdec
    import opdec_pkg::*;
#(
    parameter int LVL_W          = 2,
    parameter int CHK_LONG_LEVEL = 2,
    parameter int CC_READ_LEVEL  = 1,
    parameter int RET_DEAL_LEVEL = 1,
    parameter int LONG_BR_LEVEL  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [15:0]      in_word,
    input  logic [LVL_W-1:0] cpu_level,
    output logic             out_valid,
    output logic [5:0]       out_op,
    output logic [1:0]       out_size,
    output logic [3:0]       out_cond,
    output logic [2:0]       out_reg_hi,
    output logic [2:0]       out_mode_lo,
    output logic [2:0]       out_reg_lo,
    output logic [3:0]       out_quick,
    output logic             out_shift_left,
    output logic             out_count_reg,
    output logic [1:0]       out_ext_words,
    output logic             out_illegal,
    output logic             out_line_a,
    output logic             out_line_f
);
    typedef struct packed {
        logic        valid;
        logic [11:0] fld;
        dec_t        dec;
    } state_t;

    localparam state_t STATE_RST = '{valid: 1'b0, fld: 12'd0, dec: DEC_OTHER};

    dec_t   dec_imm, dec_misc, dec_qbm, dec_shift, dec_sel;
    state_t st_d, st_q;

    opdec_imm_logic u_imm (
        .w   (in_word[11:0]),
        .dec (dec_imm)
    );

    opdec_misc #(
        .LVL_W          (LVL_W),
        .CHK_LONG_LEVEL (CHK_LONG_LEVEL),
        .CC_READ_LEVEL  (CC_READ_LEVEL),
        .RET_DEAL_LEVEL (RET_DEAL_LEVEL)
    ) u_misc (
        .w   (in_word[11:0]),
        .lvl (cpu_level),
        .dec (dec_misc)
    );

    opdec_qbm #(
        .LVL_W         (LVL_W),
        .LONG_BR_LEVEL (LONG_BR_LEVEL)
    ) u_qbm (
        .w   (in_word[13:0]),
        .lvl (cpu_level),
        .dec (dec_qbm)
    );

    opdec_shift u_shift (
        .w   (in_word[11:0]),
        .dec (dec_shift)
    );

    // group select on bits 15:12
    always_comb begin
        dec_sel = DEC_OTHER;
        case (in_word[15:12])
            4'h0:             dec_sel = dec_imm;
            4'h4:             dec_sel = dec_misc;
            4'h5, 4'h6, 4'h7: dec_sel = dec_qbm;
            4'hA:             dec_sel.op = OP_LINE_A;
            4'hE:             dec_sel = dec_shift;
            4'hF:             dec_sel.op = OP_LINE_F;
            default:          dec_sel = DEC_OTHER;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.fld = in_word[11:0];
            st_d.dec = dec_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.valid;
    assign out_op         = st_q.dec.op;
    assign out_size       = st_q.dec.size;
    assign out_cond       = st_q.fld[11:8];
    assign out_reg_hi     = st_q.fld[11:9];
    assign out_mode_lo    = st_q.fld[5:3];
    assign out_reg_lo     = st_q.fld[2:0];
    assign out_quick      = st_q.dec.quick;
    assign out_shift_left = st_q.dec.shift_left;
    assign out_count_reg  = st_q.dec.count_reg;
    assign out_ext_words  = st_q.dec.ext;
    assign out_illegal    = st_q.dec.illegal;
    assign out_line_a     = (st_q.dec.op == OP_LINE_A);
    assign out_line_f     = (st_q.dec.op == OP_LINE_F);

endmodule

// File: rtl/opdec_checker.sv
module opdec_checker #(
    parameter int LVL_W          = 2,
    parameter int CHK_LONG_LEVEL = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [15:0]      in_word,
    input logic [LVL_W-1:0] cpu_level,
    input logic             out_valid,
    input logic [5:0]       out_op,
    input logic [1:0]       out_size,
    input logic [3:0]       out_quick,
    input logic [1:0]       out_ext_words,
    input logic             out_illegal,
    input logic             out_line_a
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_line_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[15:12] == 4'hA) |=> (out_line_a && !out_illegal && out_op == 6'd30));

    p_imm_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op >= 6'd2 && out_op <= 6'd7) |-> (out_ext_words == 2'd1));

    p_qmove_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[15:12] == 4'h7 && in_word[8]) |=> out_illegal);

    p_quick_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_op == 6'd9 || out_op == 6'd10)) |-> (out_quick != 4'd0 && out_quick <= 4'd8));

    p_bounds_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[15:12] == 4'h4 && in_word[8:6] == 3'b100 && int'(cpu_level) < CHK_LONG_LEVEL)
        |=> (out_op == 6'd20 && out_size == 2'd1));

    p_cc_read_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[15:6] == 10'b0100_0010_11 && cpu_level == '0) |=> out_illegal);

    p_ill_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word == 16'h4AFC) |=> (out_illegal && out_op == 6'd1));
endmodule

bind cisc_opdec opdec_checker #(
    .LVL_W          (LVL_W),
    .CHK_LONG_LEVEL (CHK_LONG_LEVEL)
) u_opdec_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_word       (in_word),
    .cpu_level     (cpu_level),
    .out_valid     (out_valid),
    .out_op        (out_op),
    .out_size      (out_size),
    .out_quick     (out_quick),
    .out_ext_words (out_ext_words),
    .out_illegal   (out_illegal),
    .out_line_a    (out_line_a)
);

// File: tb/tb_cisc_opdec.sv
`timescale 1ns/1ps
module tb_cisc_opdec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0;
    logic [1:0]  cpu_level = 2'd0;
    logic        out_valid;
    logic [5:0]  out_op;
    logic [1:0]  out_size;
    logic [3:0]  out_cond;
    logic [2:0]  out_reg_hi, out_mode_lo, out_reg_lo;
    logic [3:0]  out_quick;
    logic        out_shift_left, out_count_reg;
    logic [1:0]  out_ext_words;
    logic        out_illegal, out_line_a, out_line_f;

    int checks = 0;
    int fails  = 0;
    bit wd_hit = 1'b0;

    typedef struct {
        logic [15:0] word;
        int          op;
        int          sz;
        int          ext;
        int          ill;
        int          quick;
        logic [3:0]  aux;   // {line_a, line_f, shift_left, count_reg}
        string       req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    cisc_opdec dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .cpu_level(cpu_level), .out_valid(out_valid), .out_op(out_op),
        .out_size(out_size), .out_cond(out_cond), .out_reg_hi(out_reg_hi),
        .out_mode_lo(out_mode_lo), .out_reg_lo(out_reg_lo), .out_quick(out_quick),
        .out_shift_left(out_shift_left), .out_count_reg(out_count_reg),
        .out_ext_words(out_ext_words), .out_illegal(out_illegal),
        .out_line_a(out_line_a), .out_line_f(out_line_f)
    );

    task automatic apply(input logic [15:0] w, input logic [1:0] lvl,
                         input int op, input int sz, input int ext, input int ill,
                         input int quick, input logic [3:0] aux, input string req);
        exp_t e;
        @(negedge clk);
        in_word   = w;
        cpu_level = lvl;
        in_valid  = 1'b1;
        e.word = w; e.op = op; e.sz = sz; e.ext = ext; e.ill = ill;
        e.quick = quick; e.aux = aux; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: one result per cycle with out_valid, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected out_valid: actual op=%0d expected no result", out_op);
                end else begin
                    exp_t e;
                    logic [3:0] aux_act;
                    e = sb.pop_front();
                    aux_act = {out_line_a, out_line_f, out_shift_left, out_count_reg};
                    if (int'(out_op) != e.op || int'(out_size) != e.sz ||
                        int'(out_ext_words) != e.ext || int'(out_illegal) != e.ill ||
                        int'(out_quick) != e.quick || aux_act != e.aux ||
                        out_cond != e.word[11:8] || out_reg_hi != e.word[11:9] ||
                        out_mode_lo != e.word[5:3] || out_reg_lo != e.word[2:0]) begin
                        fails++;
                        $display("FAIL %s word=%h: actual op=%0d sz=%0d ext=%0d ill=%0d q=%0d aux=%b flds=%h/%h/%h/%h expected op=%0d sz=%0d ext=%0d ill=%0d q=%0d aux=%b flds=%h/%h/%h/%h",
                            e.req, e.word, out_op, out_size, out_ext_words, out_illegal, out_quick, aux_act,
                            out_cond, out_reg_hi, out_mode_lo, out_reg_lo,
                            e.op, e.sz, e.ext, e.ill, e.quick, e.aux,
                            e.word[11:8], e.word[11:9], e.word[5:3], e.word[2:0]);
                    end
                end
            end
        end
    end

    task automatic run_all();
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_op !== 6'd0) begin
            fails++;
            $display("FAIL R1 reset: actual valid=%b op=%0d expected valid=0 op=0", out_valid, out_op);
        end
        rst_n = 1'b1;
        // R2 unimplemented lines
        apply(16'hA123, 2'd0, 30, 3, 0, 0, 0, 4'b1000, "R2");
        apply(16'hF000, 2'd2, 31, 3, 0, 0, 0, 4'b0100, "R2");
        // R3 immediate logic to condition byte / status word
        apply(16'h003C, 2'd0, 2, 0, 1, 0, 0, 4'b0000, "R3");
        apply(16'h023C, 2'd0, 3, 0, 1, 0, 0, 4'b0000, "R3");
        apply(16'h0A3C, 2'd0, 4, 0, 1, 0, 0, 4'b0000, "R3");
        apply(16'h007C, 2'd1, 5, 1, 1, 0, 0, 4'b0000, "R3");
        apply(16'h027C, 2'd1, 6, 1, 1, 0, 0, 4'b0000, "R3");
        apply(16'h0A7C, 2'd1, 7, 1, 1, 0, 0, 4'b0000, "R3");
        apply(16'h043C, 2'd0, 32, 3, 0, 1, 0, 4'b0000, "R3");
        apply(16'h00BC, 2'd0, 32, 3, 0, 1, 0, 4'b0000, "R3");
        // R4 move-quick
        apply(16'h7A05, 2'd0, 8, 2, 0, 0, 0, 4'b0000, "R4");
        apply(16'h7105, 2'd0, 32, 3, 0, 1, 0, 4'b0000, "R4");
        // R5 add/sub quick
        apply(16'h5E40, 2'd0, 9, 1, 0, 0, 7, 4'b0000, "R5");
        apply(16'h5140, 2'd0, 10, 1, 0, 0, 8, 4'b0000, "R5");
        apply(16'h5382, 2'd0, 10, 2, 0, 0, 1, 4'b0000, "R5");
        // R6 alternate decodings at size 11
        apply(16'h57C8, 2'd0, 12, 3, 1, 0, 0, 4'b0000, "R6");
        apply(16'h56C0, 2'd0, 11, 3, 0, 0, 0, 4'b0000, "R6");
        // R7 register shifts
        apply(16'hE308, 2'd0, 17, 0, 0, 0, 1, 4'b0010, "R7");
        apply(16'hE020, 2'd0, 16, 0, 0, 0, 0, 4'b0001, "R7");
        apply(16'hE018, 2'd0, 19, 0, 0, 0, 8, 4'b0000, "R7");
        apply(16'hE550, 2'd0, 18, 1, 0, 0, 2, 4'b0010, "R7");
        // R8 memory shifts and the bit-11 case
        apply(16'hE2D0, 2'd0, 17, 1, 0, 0, 1, 4'b0000, "R8");
        apply(16'hE5D0, 2'd0, 18, 1, 0, 0, 1, 4'b0010, "R8");
        apply(16'hEAC0, 2'd2, 0, 3, 0, 0, 0, 4'b0000, "R8");
        // R9 bounds check by level
        apply(16'h4180, 2'd0, 20, 1, 0, 0, 0, 4'b0000, "R9");
        apply(16'h4100, 2'd0, 20, 1, 0, 0, 0, 4'b0000, "R9");
        apply(16'h4100, 2'd1, 20, 1, 0, 0, 0, 4'b0000, "R9");
        apply(16'h4100, 2'd2, 20, 2, 0, 0, 0, 4'b0000, "R9");
        // R10 condition-code read by level
        apply(16'h42C0, 2'd0, 32, 3, 0, 1, 0, 4'b0000, "R10");
        apply(16'h42C0, 2'd1, 21, 1, 0, 0, 0, 4'b0000, "R10");
        // R11 dedicated illegal word and control words
        apply(16'h4AFC, 2'd2, 1, 3, 0, 1, 0, 4'b0000, "R11");
        for (int i = 0; i < 8; i++) begin
            int ex;
            ex = (i == 2 || i == 4) ? 1 : 0;
            apply(16'h4E70 + 16'(i), 2'd1, 22 + i, 3, ex, 0, 0, 4'b0000, "R11");
        end
        apply(16'h4E74, 2'd0, 32, 3, 0, 1, 0, 4'b0000, "R11");
        // R12 branches
        apply(16'h6010, 2'd0, 13, 0, 0, 0, 0, 4'b0000, "R12");
        apply(16'h6100, 2'd0, 14, 1, 1, 0, 0, 4'b0000, "R12");
        apply(16'h67FF, 2'd2, 15, 2, 2, 0, 0, 4'b0000, "R12");
        apply(16'h67FF, 2'd1, 15, 0, 0, 0, 0, 4'b0000, "R12");
        // R13 unclassified words
        apply(16'h1200, 2'd0, 0, 3, 0, 0, 0, 4'b0000, "R13");
        apply(16'h0000, 2'd0, 0, 3, 0, 0, 0, 4'b0000, "R13");
        // R1 idle cycle gives no result
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 16'h4AFC;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle: actual valid=%b expected valid=0", out_valid);
        end
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 results missing: actual pending=%0d expected 0", sb.size());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule